// File: doc/BRIEF.md
# Masked Sector Scan Comparator

This block searches one disk track for a sector whose contents relate in a chosen way to a 256-byte search argument. Before a scan, the argument is written into a local buffer one byte at a time. The sector data of the current track is then streamed in. Each byte carries a valid strobe and flags that mark the first and the last byte of a sector. The block compares every streamed byte with the argument byte at the same offset. It skips argument positions that hold 0xFF, and the first unmasked byte that differs decides whether the sector ranks low or high against the argument.

The scan stops at the first sector that meets the requested test. The block then reports that sector's number, in the numbering of the selected surface, and raises scan-found. If no sector on the track qualifies, the block signals completion and sets a no-record status bit instead. The results stay in place until the next scan is started.

The controller has four states. ST_IDLE is entered after reset. On start it moves to ST_SCAN. ST_SCAN evaluates each sector at its last byte. It moves to ST_FOUND on the first qualifying sector, or to ST_NOREC after the last sector of the track has failed. Otherwise it stays in ST_SCAN. ST_FOUND and ST_NOREC hold the result and return to ST_SCAN on the next start.

Top module: `sector_scan_top`

## Requirements
- R1: After reset the block is idle: busy, done, scan_found, hit_sector, hit_ctrl_byte and sense are all zero.
- R2: A write with arg_we high stores arg_data at offset arg_addr of the argument buffer. The byte at offset i is compared with the i-th byte of every sector, counted from 0 at the byte flagged sector_first.
- R3: An argument byte of 0xFF is a wildcard. The sector byte at that offset never affects the result, whatever its value.
- R4: Within a sector, the first unmasked byte whose value differs from the argument byte decides the relation. A sector byte below the argument byte makes the sector LOW, and one above makes it HIGH. Later bytes do not change a decided relation. A sector with no unmasked difference is EQUAL.
- R5: The mode value captured at start selects the test. Code 0 accepts EQUAL, code 1 accepts EQUAL or LOW, and code 2 accepts EQUAL or HIGH. The reserved code 3 behaves as code 0.
- R6: The scan ends at the first accepted sector. done is high for exactly one cycle, the cycle after the clock edge that takes that sector's last byte. Bytes that follow do not change any output.
- R7: Sector numbering depends on the surface captured at start. With surface 0 the sectors are numbered 0 to 23 in stream order, and with surface 1 they are numbered 32 to 55. hit_ctrl_byte carries hit_sector in bits 7:2, with bits 1:0 zero.
- R8: An accepted sector sets scan_found and sense bit 7 (value 0x0080), and sense bit 10 stays 0.
- R9: If none of the 24 sectors is accepted, done pulses after the last byte of the 24th sector. scan_found stays 0 and sense bit 10 (value 0x0400) is set.
- R10: start is ignored while busy. Stream bytes are ignored while not busy.
- R11: An accepted start clears scan_found, hit_sector and sense, and raises busy, all on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arg_we | input | 1 | Argument buffer write strobe |
| arg_addr | input | 8 | Argument buffer write offset |
| arg_data | input | 8 | Argument byte to write |
| start | input | 1 | Begin a scan of one track |
| mode | input | 2 | Scan test: 0 equal, 1 low-or-equal, 2 high-or-equal |
| surface | input | 1 | 0 upper surface, 1 lower surface |
| byte_valid | input | 1 | Stream byte strobe |
| byte_data | input | 8 | Stream sector byte |
| sector_first | input | 1 | Marks the first byte of a sector |
| sector_last | input | 1 | Marks the last byte of a sector |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| scan_found | output | 1 | A sector satisfied the test |
| hit_sector | output | 6 | Number of the accepted sector |
| hit_ctrl_byte | output | 8 | hit_sector placed in bits 7:2 |
| sense | output | 16 | Status: bit 7 hit, bit 10 no record |

## Verification
Each scan is run with a track built from sectors of known relation to the argument. There are exactly equal sectors whose bytes at wildcard offsets differ from the argument. There are sectors that are low or high at a single offset. Some sectors are high at an early offset and low at a later one, which separates first-difference ordering from last-difference or majority logic. The patterns run in every mode and on both surfaces, with the target sector at the first, a middle or the last position, and with no qualifying sector at all. This separates the acceptance rules, the numbering offset, the stop-at-first behaviour and the no-record path. Directed cases cover bytes sent while idle and a start pulse sent during a scan with a different mode.

// File: rtl/scan_cmp_pkg.sv
package scan_cmp_pkg;

    typedef enum logic [1:0] {
        REL_EQ   = 2'd0,
        REL_LOW  = 2'd1,
        REL_HIGH = 2'd2
    } rel_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_FOUND = 2'd2,
        ST_NOREC = 2'd3
    } state_t;

    localparam logic [1:0] MODE_EQ = 2'd0;
    localparam logic [1:0] MODE_LE = 2'd1;
    localparam logic [1:0] MODE_GE = 2'd2;

    localparam logic [7:0] WILDCARD = 8'hFF;

    localparam int SENSE_HIT_BIT   = 7;
    localparam int SENSE_NOREC_BIT = 10;

    // Does a sector with relation r satisfy scan test m (code 3 acts as equal)
    function automatic logic mode_accepts(input logic [1:0] m, input rel_t r);
        logic ok;
        case (m)
            MODE_LE: ok = (r != REL_HIGH);
            MODE_GE: ok = (r != REL_LOW);
            default: ok = (r == REL_EQ);
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/scan_arg_buf.sv
module scan_arg_buf #(
    parameter int BYTES  = 256,
    parameter int ADDR_W = $clog2(BYTES)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);

    logic [7:0] mem [BYTES];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/scan_byte_cmp.sv
module scan_byte_cmp
    import scan_cmp_pkg::*;
(
    input  logic [7:0] arg_byte,
    input  logic [7:0] data_byte,
    input  logic       restart,
    input  rel_t       rel_in,
    output rel_t       rel_out
);

    rel_t base;

    always_comb begin
        base    = restart ? REL_EQ : rel_in;
        rel_out = base;
        if (base == REL_EQ && arg_byte != WILDCARD && data_byte != arg_byte) begin
            rel_out = (data_byte < arg_byte) ? REL_LOW : REL_HIGH;
        end
    end

endmodule

// File: rtl/sector_scan_top.sv
module sector_scan_top
    import scan_cmp_pkg::*;
#(
    parameter int SECTOR_BYTES  = 256,
    parameter int TRACK_SECTORS = 24,
    parameter int LOWER_BASE    = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        arg_we,
    input  logic [7:0]  arg_addr,
    input  logic [7:0]  arg_data,
    input  logic        start,
    input  logic [1:0]  mode,
    input  logic        surface,
    input  logic        byte_valid,
    input  logic [7:0]  byte_data,
    input  logic        sector_first,
    input  logic        sector_last,
    output logic        busy,
    output logic        done,
    output logic        scan_found,
    output logic [5:0]  hit_sector,
    output logic [7:0]  hit_ctrl_byte,
    output logic [15:0] sense
);

    localparam int POS_W = $clog2(SECTOR_BYTES);
    localparam int IDX_W = $clog2(TRACK_SECTORS);
    localparam int NUM_W = $clog2(LOWER_BASE + TRACK_SECTORS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TRACK_SECTORS - 1);

    state_t            state_q, state_d;
    logic [POS_W-1:0]  pos_q, rd_pos;
    logic [IDX_W-1:0]  idx_q;
    logic [1:0]        mode_q;
    logic              surf_q;
    rel_t              rel_q, rel_nx;
    logic [7:0]        arg_rd;
    logic              take, eval, accept, go;
    logic [NUM_W-1:0]  cur_num;
    logic [NUM_W-1:0]  hit_q;

    assign busy   = (state_q == ST_SCAN);
    assign take   = busy && byte_valid;
    assign eval   = take && sector_last;
    assign go     = !busy && start;
    assign rd_pos = sector_first ? '0 : pos_q;
    assign accept = mode_accepts(mode_q, rel_nx);
    assign cur_num = surf_q ? (NUM_W'(LOWER_BASE) + NUM_W'(idx_q)) : NUM_W'(idx_q);

    scan_arg_buf #(.BYTES(SECTOR_BYTES), .ADDR_W(POS_W)) u_buf (
        .clk   (clk),
        .we    (arg_we),
        .waddr (arg_addr[POS_W-1:0]),
        .wdata (arg_data),
        .raddr (rd_pos),
        .rdata (arg_rd)
    );

    scan_byte_cmp u_cmp (
        .arg_byte  (arg_rd),
        .data_byte (byte_data),
        .restart   (sector_first),
        .rel_in    (rel_q),
        .rel_out   (rel_nx)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_FOUND, ST_NOREC: begin
                if (start) state_d = ST_SCAN;
            end
            ST_SCAN: begin
                if (eval) begin
                    if (accept)               state_d = ST_FOUND;
                    else if (idx_q == LAST_IDX) state_d = ST_NOREC;
                end
            end
        endcase
    end

    // State and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pos_q   <= '0;
            idx_q   <= '0;
            mode_q  <= MODE_EQ;
            surf_q  <= 1'b0;
            rel_q   <= REL_EQ;
        end else begin
            state_q <= state_d;
            if (go) begin
                pos_q  <= '0;
                idx_q  <= '0;
                mode_q <= mode;
                surf_q <= surface;
                rel_q  <= REL_EQ;
            end else if (take) begin
                pos_q <= rd_pos + POS_W'(1);
                rel_q <= rel_nx;
                if (sector_last && idx_q != LAST_IDX) idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done       <= 1'b0;
            scan_found <= 1'b0;
            hit_q      <= '0;
            sense      <= '0;
        end else begin
            done <= 1'b0;
            if (go) begin
                scan_found <= 1'b0;
                hit_q      <= '0;
                sense      <= '0;
            end else if (eval) begin
                if (accept) begin
                    done                 <= 1'b1;
                    scan_found           <= 1'b1;
                    hit_q                <= cur_num;
                    sense[SENSE_HIT_BIT] <= 1'b1;
                end else if (idx_q == LAST_IDX) begin
                    done                   <= 1'b1;
                    sense[SENSE_NOREC_BIT] <= 1'b1;
                end
            end
        end
    end

    assign hit_sector    = 6'(hit_q);
    assign hit_ctrl_byte = {hit_sector, 2'b00};

    // Assertions
    assert_wildcard_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !sector_first && arg_rd == WILDCARD) |=> (rel_q == $past(rel_q)));

    assert_decided_sticks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !sector_first && rel_q != REL_EQ) |=> (rel_q == $past(rel_q)));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_ends_scan_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_sector_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        scan_found |-> (hit_sector < 6'(TRACK_SECTORS) ||
                        (hit_sector >= 6'(LOWER_BASE) && hit_sector < 6'(LOWER_BASE + TRACK_SECTORS))));

    assert_found_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
        scan_found |-> (sense[SENSE_HIT_BIT] && !sense[SENSE_NOREC_BIT]));

    assert_norec_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !scan_found) |-> sense[SENSE_NOREC_BIT]);

    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (mode_q == $past(mode_q) && surf_q == $past(surf_q)));

    assert_start_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !scan_found && sense == 16'h0000));

endmodule

// File: tb/sector_scan_top_bench.sv
module sector_scan_top_bench;

    typedef struct packed {
        logic [1:0] mode;
        logic       surf;
        logic       dflt;   // 0: other sectors LOW, 1: other sectors HIGH
        logic [4:0] eq;     // 31 = none
        logic [4:0] lo;
        logic [4:0] hi;
        logic [4:0] mix;    // high at offset 10, low at offset 200
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 1'b0, 5'd5,  5'd31, 5'd31, 5'd31},
        '{2'd0, 1'b1, 1'b1, 5'd0,  5'd31, 5'd31, 5'd31},
        '{2'd0, 1'b0, 1'b0, 5'd31, 5'd3,  5'd31, 5'd31},
        '{2'd1, 1'b0, 1'b1, 5'd10, 5'd4,  5'd31, 5'd31},
        '{2'd1, 1'b1, 1'b1, 5'd31, 5'd31, 5'd31, 5'd2 },
        '{2'd2, 1'b1, 1'b0, 5'd31, 5'd31, 5'd23, 5'd31},
        '{2'd2, 1'b0, 1'b0, 5'd9,  5'd31, 5'd31, 5'd7 },
        '{2'd0, 1'b1, 1'b0, 5'd23, 5'd31, 5'd31, 5'd31},
        '{2'd2, 1'b0, 1'b1, 5'd31, 5'd31, 5'd31, 5'd31},
        '{2'd3, 1'b0, 1'b1, 5'd12, 5'd31, 5'd31, 5'd31}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arg_we = 1'b0;
    logic [7:0]  arg_addr = '0;
    logic [7:0]  arg_data = '0;
    logic        start = 1'b0;
    logic [1:0]  mode = '0;
    logic        surface = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        sector_first = 1'b0;
    logic        sector_last = 1'b0;
    logic        busy, done, scan_found;
    logic [5:0]  hit_sector;
    logic [7:0]  hit_ctrl_byte;
    logic [15:0] sense;

    int errors = 0;
    int checks = 0;
    int done_cnt = 0;

    always #5 clk = ~clk;

    sector_scan_top u_sector_scan_top (
        .clk, .rst_n, .arg_we, .arg_addr, .arg_data, .start, .mode, .surface,
        .byte_valid, .byte_data, .sector_first, .sector_last,
        .busy, .done, .scan_found, .hit_sector, .hit_ctrl_byte, .sense
    );

    always @(posedge clk) if (done) done_cnt <= done_cnt + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] argv(input int i);
        return (i == 50 || i == 150) ? 8'hFF : 8'(8'h20 + (i % 64));
    endfunction

    function automatic logic [7:0] sbyte(input vec_t v, input int s, input int i);
        logic [7:0] b;
        b = argv(i);
        if (i == 50 || i == 150) b = 8'h33 ^ 8'(s);
        else if (s == int'(v.eq)) b = b;
        else if (s == int'(v.lo))  begin if (i == 100) b = b - 8'd1; end
        else if (s == int'(v.hi))  begin if (i == 100) b = b + 8'd1; end
        else if (s == int'(v.mix)) begin
            if (i == 10) b = b + 8'd1;
            if (i == 200) b = b - 8'd1;
        end
        else if (i == 5) b = v.dflt ? b + 8'd1 : b - 8'd1;
        return b;
    endfunction

    // 0 equal, 1 low, 2 high
    function automatic int rel_of(input vec_t v, input int s);
        if (s == int'(v.eq)) return 0;
        if (s == int'(v.lo)) return 1;
        if (s == int'(v.hi) || s == int'(v.mix)) return 2;
        return v.dflt ? 2 : 1;
    endfunction

    function automatic bit accepts(input logic [1:0] m, input int r);
        if (m == 2'd1) return r != 2;
        if (m == 2'd2) return r != 1;
        return r == 0;
    endfunction

    task automatic send_sector(input vec_t v, input int s, input bit poke, input logic [1:0] pmode);
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            byte_valid   = 1'b1;
            byte_data    = sbyte(v, s, i);
            sector_first = (i == 0);
            sector_last  = (i == 255);
            start        = poke && (i == 3);
            mode         = (poke && i == 3) ? pmode : v.mode;
            surface      = poke && (i == 3) ? ~v.surf : v.surf;
        end
        @(negedge clk);
        byte_valid = 1'b0; sector_first = 1'b0; sector_last = 1'b0; start = 1'b0;
    endtask

    task automatic run_vec(input vec_t v, input bit poke, input string tag);
        int exp_idx;
        exp_idx = -1;
        for (int s = 0; s < 24; s++) if (exp_idx < 0 && accepts(v.mode, rel_of(v, s))) exp_idx = s;
        @(negedge clk);
        mode = v.mode; surface = v.surf; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({tag, " R11 busy after start"}, 32'(busy), 32'd1);
        check({tag, " R11 cleared"}, {15'd0, scan_found, sense}, 32'd0);
        done_cnt = 0;
        for (int s = 0; s < 24; s++) send_sector(v, s, poke && s == 0, 2'd1);
        repeat (2) @(negedge clk);
        check({tag, " R6 single done"}, 32'(done_cnt), 32'd1);
        check({tag, " R10 idle after"}, 32'(busy), 32'd0);
        if (exp_idx >= 0) begin
            logic [5:0] num;
            num = v.surf ? 6'(32 + exp_idx) : 6'(exp_idx);
            check({tag, " R5 R8 found"}, 32'(scan_found), 32'd1);
            check({tag, " R7 hit sector"}, 32'(hit_sector), 32'(num));
            check({tag, " R7 ctrl byte"}, 32'(hit_ctrl_byte), 32'({num, 2'b00}));
            check({tag, " R8 sense"}, 32'(sense), 32'h0080);
        end else begin
            check({tag, " R9 not found"}, 32'(scan_found), 32'd0);
            check({tag, " R9 sense"}, 32'(sense), 32'h0400);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 done", 32'(done), 32'd0);
        check("R1 found", 32'(scan_found), 32'd0);
        check("R1 sector", 32'(hit_sector), 32'd0);
        check("R1 ctrl", 32'(hit_ctrl_byte), 32'd0);
        check("R1 sense", 32'(sense), 32'd0);
        rst_n = 1'b1;
        // R2 load the argument
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            arg_we = 1'b1; arg_addr = 8'(i); arg_data = argv(i);
        end
        @(negedge clk);
        arg_we = 1'b0;
        // R10 bytes while idle are ignored
        done_cnt = 0;
        send_sector(VECS[0], 5, 1'b0, 2'd0);
        repeat (2) @(negedge clk);
        check("R10 idle bytes done", 32'(done_cnt), 32'd0);
        check("R10 idle bytes found", 32'(scan_found), 32'd0);
        check("R10 idle bytes sense", 32'(sense), 32'd0);
        // Table of vectors: R3 R4 R5 R6 R7 R8 R9
        for (int k = 0; k < NV; k++) run_vec(VECS[k], 1'b0, $sformatf("vec%0d", k));
        // R10 start during scan with another mode and surface is ignored
        run_vec(VECS[0], 1'b1, "midstart");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule